// File: doc/BRIEF.md
# Windowed Register Address Generator

This block turns a 4-bit register number into the memory address of that register, for a processor that keeps its general registers in RAM rather than in flops. Only a workspace pointer lives on chip. Register 0 sits at the pointer, and the other fifteen follow it as consecutive 16-bit words, two bytes apart. Switching context therefore costs only the pointer, the program counter and the status word.

Two bases are kept registered: the pointer itself and the pointer plus half the register file (16 bytes). The top bit of the register number picks one of them. The low three bits, scaled to bytes, are added as a small offset. No full-width add of pointer and register number sits on the access path.

The pointer also works as a stack of register windows. A call moves it up by 8 words, so a callee's R0..R7 are the caller's R8..R15. An allocation moves it up further to make room for locals. A return moves it back down by the sum of that frame's call step and allocations. An 8-entry frame stack records each frame's total.

The request side is valid/ready. The requester raises `req_valid` with `req_sel` and holds both steady until it sees `req_ready` high at a rising edge. The transfer happens at that edge. The address follows one cycle later with a one-cycle `addr_valid` strobe. The address output has no back-pressure, so the consumer must take it in that cycle. `req_ready` is low exactly while `busy` is high.

Top module: `wsa_addr_gen`

## Requirements
- R1: After reset the pointer equals RESET_PTR (0) and the frame stack is empty. `busy`, `addr_valid` and `stk_err` are low and `req_ready` is high.
- R2: A request accepted at an edge gives, after the next edge, `addr_valid` high for one cycle. When `req_sel[3]`=0 the address is pointer + 2*`req_sel[2:0]`. When `req_sel[3]`=1 it is pointer + 16 + 2*`req_sel[2:0]`. The sum is taken modulo 2^16.
- R3: In the cycle after any pointer change, `busy` is high and `req_ready` is low. A pending request waits and is accepted in the following cycle, using the new pointer.
- R4: `load_en` sets the pointer to `load_ptr` and empties the frame stack.
- R5: `call_en` raises the pointer by 16 bytes and pushes a new frame whose total is 16. The callee's register n (n<8) then has the same address as the caller's register n+8.
- R6: `alloc_en` raises the pointer by 2*`alloc_words` bytes and adds that amount to the top frame's total. With no frame open it is ignored and raises `stk_err`.
- R7: `ret_en` lowers the pointer by the top frame's total and pops that frame.
- R8: `ret_en` with an empty frame stack leaves the pointer unchanged and raises `stk_err` for one cycle, one edge after the command.
- R9: `call_en` while 8 frames are open leaves the pointer unchanged and raises `stk_err`.
- R10: Only one command acts per cycle. The priority is load, then return, then call, then allocate. Commands that lose are ignored and do not raise `stk_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register address request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sel | input | 4 | Register number |
| addr_valid | output | 1 | One-cycle strobe marking `addr` |
| addr | output | 16 | Byte address of the register |
| load_en | input | 1 | Load the pointer from `load_ptr` |
| load_ptr | input | 16 | New pointer value |
| call_en | input | 1 | Open a window for a call |
| alloc_en | input | 1 | Reserve local words in the current frame |
| alloc_words | input | 8 | Number of words to reserve |
| ret_en | input | 1 | Close the current frame |
| busy | output | 1 | Upper base is being refreshed |
| stk_err | output | 1 | Frame stack underflow, overflow or allocation with no frame |

## Verification
The bench uses the default parameters: 16-bit addresses, 16 registers, an 8-word call step and an 8-deep frame stack. The small frame stack lets the bench reach both the full and the empty case with a handful of calls and returns. A pointer loaded near the top of the address space makes the upper-window offset wrap past zero. The table walks both halves of the register file at three pointers. Directed sequences then stack calls, allocations and returns, collide commands in one cycle, and hold a request across the busy cycle.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_RET   = 3'd2,
    OP_CALL  = 3'd3,
    OP_ALLOC = 3'd4
  } wsa_op_e;
endpackage

// File: rtl/wsa_cmd_arb.sv
module wsa_cmd_arb
  import wsa_pkg::*;
(
  input  logic    load_en,
  input  logic    ret_en,
  input  logic    call_en,
  input  logic    alloc_en,
  input  logic    stk_empty,
  input  logic    stk_full,
  output wsa_op_e op,
  output logic    err
);
  // fixed priority: load > return > call > allocate (R10)
  always_comb begin
    op  = OP_NONE;
    err = 1'b0;
    if (load_en) begin
      op = OP_LOAD;
    end else if (ret_en) begin
      if (stk_empty) err = 1'b1;
      else           op  = OP_RET;
    end else if (call_en) begin
      if (stk_full)  err = 1'b1;
      else           op  = OP_CALL;
    end else if (alloc_en) begin
      if (stk_empty) err = 1'b1;
      else           op  = OP_ALLOC;
    end
  end
endmodule

// File: rtl/wsa_frame_stack.sv
module wsa_frame_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         grow,
  input  logic [W-1:0] grow_val,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [CNT_W-1:0] depth_q;
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] top_idx;

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(depth_q - CNT_W'(1));
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     depth_q <= '0;
    else if (clear) depth_q <= '0;
    else if (push)  depth_q <= depth_q + CNT_W'(1);
    else if (pop)   depth_q <= depth_q - CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (!clear && push && depth_q == CNT_W'(i))
        mem[i] <= push_val;
      else if (!clear && grow && !empty && top_idx == IDX_W'(i))
        mem[i] <= mem[i] + grow_val;
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CNT_W'(DEPTH));
  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full && push |-> clear);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop |-> clear);
endmodule

// File: rtl/wsa_base_regs.sv
module wsa_base_regs #(
  parameter int         W          = 16,
  parameter int         HALF_BYTES = 16,
  parameter logic [W-1:0] RESET_PTR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] ptr,
  output logic [W-1:0] base_hi,
  output logic         busy
);
  logic stale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= RESET_PTR;
      base_hi <= RESET_PTR + W'(HALF_BYTES);
      stale_q <= 1'b0;
    end else begin
      if (we) ptr <= nxt;
      stale_q <= we;
      if (stale_q) base_hi <= ptr + W'(HALF_BYTES);
    end
  end

  assign busy = stale_q;

  assert_upper_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> base_hi == ptr + W'(HALF_BYTES));
  assert_refresh_after_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> busy);
endmodule

// File: rtl/wsa_addr_gen.sv
module wsa_addr_gen
  import wsa_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SEL_W       = 4,
  parameter int WORD_BYTES  = 2,
  parameter int CALL_WORDS  = 8,
  parameter int FRAME_DEPTH = 8,
  parameter int ALLOC_W     = 8,
  parameter logic [ADDR_W-1:0] RESET_PTR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_ptr,
  input  logic              call_en,
  input  logic              alloc_en,
  input  logic [ALLOC_W-1:0] alloc_words,
  input  logic              ret_en,
  output logic              busy,
  output logic              stk_err
);
  localparam int NUM_REGS   = 1 << SEL_W;
  localparam int HALF_BYTES = (NUM_REGS / 2) * WORD_BYTES;
  localparam int CALL_BYTES = CALL_WORDS * WORD_BYTES;
  localparam int OFF_W      = SEL_W - 1;

  wsa_op_e           op;
  logic              arb_err;
  logic              stk_empty, stk_full;
  logic [ADDR_W-1:0] frame_total;
  logic [ADDR_W-1:0] alloc_bytes;
  logic [ADDR_W-1:0] ptr, base_hi, ptr_nxt;
  logic [ADDR_W-1:0] offset, base_sel;
  logic              accept;

  wsa_cmd_arb u_arb (
    .load_en  (load_en),
    .ret_en   (ret_en),
    .call_en  (call_en),
    .alloc_en (alloc_en),
    .stk_empty(stk_empty),
    .stk_full (stk_full),
    .op       (op),
    .err      (arb_err)
  );

  assign alloc_bytes = ADDR_W'(alloc_words) * ADDR_W'(WORD_BYTES);

  wsa_frame_stack #(.W(ADDR_W), .DEPTH(FRAME_DEPTH)) u_frames (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (op == OP_LOAD),
    .push    (op == OP_CALL),
    .push_val(ADDR_W'(CALL_BYTES)),
    .grow    (op == OP_ALLOC),
    .grow_val(alloc_bytes),
    .pop     (op == OP_RET),
    .top     (frame_total),
    .empty   (stk_empty),
    .full    (stk_full)
  );

  always_comb begin
    unique case (op)
      OP_LOAD:  ptr_nxt = load_ptr;
      OP_RET:   ptr_nxt = ptr - frame_total;
      OP_CALL:  ptr_nxt = ptr + ADDR_W'(CALL_BYTES);
      OP_ALLOC: ptr_nxt = ptr + alloc_bytes;
      default:  ptr_nxt = ptr;
    endcase
  end

  wsa_base_regs #(.W(ADDR_W), .HALF_BYTES(HALF_BYTES), .RESET_PTR(RESET_PTR)) u_bases (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (op != OP_NONE),
    .nxt    (ptr_nxt),
    .ptr    (ptr),
    .base_hi(base_hi),
    .busy   (busy)
  );

  // address path: base picked by the top select bit, short scaled offset
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign base_sel  = req_sel[SEL_W-1] ? base_hi : ptr;
  assign offset    = ADDR_W'(req_sel[OFF_W-1:0]) * ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      stk_err    <= 1'b0;
    end else begin
      addr_valid <= accept;
      stk_err    <= arb_err;
      if (accept) addr <= base_sel + offset;
    end
  end

  assert_strobe_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(req_valid && req_ready));
  assert_busy_on_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != $past(ptr) |-> busy);
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ptr == $past(load_ptr));
  assert_call_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !ret_en && call_en && !stk_full |=> ptr == $past(ptr) + ADDR_W'(CALL_BYTES));
  assert_empty_ret_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && ret_en && stk_empty |=> stk_err && $stable(ptr));
  assert_full_call_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !ret_en && call_en && stk_full |=> stk_err && $stable(ptr));
endmodule

// File: tb/test_wsa_addr_gen.sv
module test_wsa_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sel = '0;
  logic        addr_valid;
  logic [15:0] addr;
  logic        load_en = 1'b0;
  logic [15:0] load_ptr = '0;
  logic        call_en = 1'b0;
  logic        alloc_en = 1'b0;
  logic [7:0]  alloc_words = '0;
  logic        ret_en = 1'b0;
  logic        busy;
  logic        stk_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wsa_addr_gen i_wsa_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .addr_valid(addr_valid), .addr(addr),
    .load_en(load_en), .load_ptr(load_ptr),
    .call_en(call_en), .alloc_en(alloc_en), .alloc_words(alloc_words),
    .ret_en(ret_en), .busy(busy), .stk_err(stk_err)
  );

  // {pointer, register number, expected byte address}
  localparam logic [35:0] VEC [8] = '{
    {16'h1000, 4'd0,  16'h1000},
    {16'h1000, 4'd5,  16'h100A},
    {16'h1000, 4'd8,  16'h1010},
    {16'h1000, 4'd15, 16'h101E},
    {16'h2346, 4'd3,  16'h234C},
    {16'h2346, 4'd12, 16'h235E},
    {16'hFFF0, 4'd9,  16'h0002},
    {16'hFFF0, 4'd7,  16'hFFFE}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic command(input logic l, input logic [15:0] lv, input logic r,
                         input logic c, input logic a, input logic [7:0] aw);
    @(negedge clk);
    load_en = l; load_ptr = lv; ret_en = r; call_en = c; alloc_en = a; alloc_words = aw;
    @(negedge clk);
    load_en = 0; ret_en = 0; call_en = 0; alloc_en = 0;
  endtask

  task automatic lookup(input logic [3:0] sel, input logic [15:0] exp, input string tag);
    req_valid = 1'b1; req_sel = sel;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({31'd0, addr_valid}, 32'd1, tag);
    check({16'd0, addr}, {16'd0, exp}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({31'd0, busy}, 0, "R1 busy");
    check({31'd0, req_ready}, 1, "R1 ready");
    check({31'd0, addr_valid}, 0, "R1 addr_valid");
    check({31'd0, stk_err}, 0, "R1 stk_err");
    lookup(4'd0, 16'h0000, "R1 reset pointer");

    // R2 table walk, both window halves
    for (int i = 0; i < 8; i++) begin
      command(1, VEC[i][35:20], 0, 0, 0, 0);
      lookup(VEC[i][19:16], VEC[i][15:0], "R2 table");
    end

    // R3 busy after a pointer move, request held then accepted
    command(1, 16'h1000, 0, 0, 0, 0);
    check({31'd0, busy}, 1, "R3 busy");
    check({31'd0, req_ready}, 0, "R3 ready low");
    lookup(4'd8, 16'h1010, "R3 held request");
    @(negedge clk);
    check({31'd0, addr_valid}, 0, "R2 single strobe");

    // R5 call window overlap
    command(0, 0, 0, 1, 0, 0);
    lookup(4'd0, 16'h1010, "R5 callee R0 = caller R8");
    lookup(4'd7, 16'h101E, "R5 callee R7");
    lookup(4'd8, 16'h1020, "R5 callee R8");
    // R6 allocate
    command(0, 0, 0, 0, 1, 8'd3);
    lookup(4'd0, 16'h1016, "R6 alloc");
    // R7 return undoes call and allocation
    command(0, 0, 1, 0, 0, 0);
    check({31'd0, stk_err}, 0, "R7 no err");
    lookup(4'd0, 16'h1000, "R7 return");
    // R8 underflow
    command(0, 0, 1, 0, 0, 0);
    check({31'd0, stk_err}, 1, "R8 err");
    lookup(4'd0, 16'h1000, "R8 pointer kept");
    // R6 allocate with no frame
    command(0, 0, 0, 0, 1, 8'd4);
    check({31'd0, stk_err}, 1, "R6 err no frame");
    lookup(4'd0, 16'h1000, "R6 ignored");

    // R9 overflow
    for (int k = 0; k < 8; k++) begin
      command(0, 0, 0, 1, 0, 0);
      check({31'd0, stk_err}, 0, "R9 no err while room");
    end
    command(0, 0, 0, 1, 0, 0);
    check({31'd0, stk_err}, 1, "R9 err full");
    lookup(4'd0, 16'h1080, "R9 pointer kept");

    // R10 priority
    command(0, 0, 1, 1, 0, 0);
    check({31'd0, stk_err}, 0, "R10 return beats call");
    lookup(4'd0, 16'h1070, "R10 return taken");
    command(1, 16'h3000, 1, 0, 0, 0);
    lookup(4'd0, 16'h3000, "R10 load beats return");
    command(0, 0, 1, 0, 0, 0);
    check({31'd0, stk_err}, 1, "R4 load empties stack");
    command(0, 0, 0, 1, 0, 0);
    command(0, 0, 1, 0, 1, 8'd5);
    lookup(4'd0, 16'h3000, "R10 return beats alloc");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule